// File: doc/BRIEF.md
# Register-triggered single-byte serial-bus master

This block is a two-wire serial-bus master that moves exactly one data byte to or from an external device. Software first loads a word-address byte, a data byte and a control byte. It then writes the target-address register, whose low bit selects a read or a write. That register write is the only trigger; there is no separate go bit. The master produces START, the address and optional word-address bytes, the data phase and STOP on open-drain SCL and SDA lines. Each line is driven through an output enable, where 1 pulls the wire low. SDA is sampled from the wire.

A protocol-select bit chooses between two formats. In one, a word-address byte follows the target address. In the other, only the target address precedes the data. A read in word-address format writes the pointer, issues a repeated START and then reads the byte. Software reads back a busy flag for its own cycle and a mirror of an external EEPROM-preload busy input. If a target does not acknowledge a byte, a sticky error flag is set.

Top module: `sbus_byte_master`

## Requirements
- R1: Register select 0 holds the target byte: bits 7:1 are the 7-bit device address and bit 0 is the direction (0 = write one byte, 1 = read one byte). The first address byte on the bus is bits 7:1 followed by the direction bit. In word-address read format the first address byte carries direction 0 instead.
- R2: A host write to select 0 while idle and with the EEPROM-busy input low starts a cycle. The busy bit (select 3, bit 5) reads 1 from the next clock until the cycle ends. A cycle lasts exactly the sum of its phase quarters times the divider: 4 for START, 4 for a repeated START, 36 per byte and 4 for STOP.
- R3: When control bit 7 (protocol select) is 0, the word-address byte (select 1) is sent after the first address byte. When it is 1, no word-address byte is sent.
- R4: A read in word-address format sends the address with direction 0, then the word address, then a repeated START, then the address with direction 1, then reads one byte. The master answers the byte with NACK (SDA released) and then STOP. The received byte is then readable at select 2.
- R5: A write sends the contents of the data register (select 2) as the single data byte, and the cycle ends with STOP.
- R6: If any address or write-data byte is not acknowledged (SDA high in its ninth bit), the master goes to STOP. It sets the sticky error bit (select 3, bit 0) and then clears busy. Writing select 3 with bit 0 = 1 clears the error; bit 0 = 0 leaves it. A clear that lands on the same clock as a new error loses to the error.
- R7: While busy, host writes to selects 0, 1 and 2 and to the protocol bit are ignored. The registers keep their values and no second cycle starts.
- R8: Control bit 4 mirrors the EEPROM-busy input. A write to select 0 while that input is 1 neither starts a cycle nor changes the register.
- R9: After reset all four registers read 00h. In the control byte, bits 6, 3, 2 and 1 always read 0.
- R10: Both line enables are 0 while idle. While SCL stays released, SDA changes only to form START, repeated START or STOP.
- R11: One quarter of an SCL bit period lasts QDIV system clocks. SCL is high for two quarters of every bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low fundamental reset |
| reg_wr | input | 1 | Host write strobe, one clock per write |
| reg_sel | input | 2 | Register select for writes: 0 target, 1 word address, 2 data, 3 control |
| reg_wdata | input | 8 | Host write data |
| rd_sel | input | 2 | Register select for the read-back mux, same map as reg_sel |
| rd_data | output | 8 | Read-back value of the selected register |
| eeprom_busy | input | 1 | High while an external preload engine owns the bus |
| scl_oe | output | 1 | SCL pull-down enable (1 drives the wire low) |
| sda_oe | output | 1 | SDA pull-down enable (1 drives the wire low) |
| sda_in | input | 1 | Level sampled from the SDA wire |

## Verification
The error flag can be set and cleared in the same cycle. This happens when a write-1-to-clear on the control byte arrives on the exact clock at which a missing address acknowledge is detected. The bench provokes it by addressing a device that is not present. It then times the clearing write to the clock 40 quarters after launch, which it computes itself, and expects the error bit to read 1 afterwards. In every cycle the bench also compares the busy bit with its own countdown model. So a target-address write that falls on the last busy clock is judged as well: it must not start a new cycle.

// File: rtl/sbus_pkg.sv
`timescale 1ns/1ps
package sbus_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR_W, ST_WORD, ST_RSTART,
    ST_ADDR_R, ST_WDATA, ST_RDATA, ST_STOP
  } step_t;

  localparam logic [1:0] SEL_TARGET = 2'd0;
  localparam logic [1:0] SEL_WORD   = 2'd1;
  localparam logic [1:0] SEL_DATA   = 2'd2;
  localparam logic [1:0] SEL_CTRL   = 2'd3;

  function automatic logic is_byte(step_t s);
    return (s == ST_ADDR_W) || (s == ST_WORD) || (s == ST_ADDR_R) ||
           (s == ST_WDATA) || (s == ST_RDATA);
  endfunction

  function automatic logic is_tx(step_t s);
    return is_byte(s) && (s != ST_RDATA);
  endfunction

  function automatic logic [7:0] tx_byte(step_t s, logic [7:0] tgt,
                                         logic [7:0] wa, logic [7:0] wd);
    case (s)
      ST_ADDR_W: return {tgt[7:1], 1'b0};
      ST_ADDR_R: return {tgt[7:1], 1'b1};
      ST_WORD:   return wa;
      ST_WDATA:  return wd;
      default:   return 8'hFF;
    endcase
  endfunction

  function automatic step_t next_step(step_t s, logic rd, logic no_word,
                                      logic nack);
    case (s)
      ST_START:  return (rd && no_word) ? ST_ADDR_R : ST_ADDR_W;
      ST_ADDR_W: return nack ? ST_STOP : (no_word ? ST_WDATA : ST_WORD);
      ST_WORD:   return nack ? ST_STOP : (rd ? ST_RSTART : ST_WDATA);
      ST_RSTART: return ST_ADDR_R;
      ST_ADDR_R: return nack ? ST_STOP : ST_RDATA;
      ST_WDATA:  return ST_STOP;
      ST_RDATA:  return ST_STOP;
      default:   return ST_IDLE;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(logic proto, logic busy,
                                             logic ee, logic err);
    return {proto, 1'b0, busy, ee, 3'b000, err};
  endfunction

endpackage

// File: rtl/sbus_qtick.sv
`timescale 1ns/1ps
module sbus_qtick #(
  parameter int QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr || !run)   cnt <= '0;
    else if (tick)          cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sbus_regs.sv
`timescale 1ns/1ps
module sbus_regs
  import sbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic [1:0] rd_sel,
  input  logic       busy,
  input  logic       eeprom_busy,
  input  logic       rx_done,
  input  logic [7:0] rx_byte,
  input  logic       nack_evt,
  output logic [7:0] rd_data,
  output logic [7:0] tgt_q,
  output logic [7:0] word_q,
  output logic [7:0] data_q,
  output logic       proto_q,
  output logic       err_q,
  output logic       launch
);
  logic wr_open;
  logic err_clr;

  assign wr_open = reg_wr && !busy;
  assign launch  = wr_open && (reg_sel == SEL_TARGET) && !eeprom_busy;
  assign err_clr = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      word_q  <= '0;
      data_q  <= '0;
      proto_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (launch) tgt_q <= reg_wdata;
      if (wr_open && (reg_sel == SEL_WORD)) word_q <= reg_wdata;
      if (rx_done) data_q <= rx_byte;
      else if (wr_open && (reg_sel == SEL_DATA)) data_q <= reg_wdata;
      if (wr_open && (reg_sel == SEL_CTRL)) proto_q <= reg_wdata[7];
      if (nack_evt)     err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_TARGET: rd_data = tgt_q;
      SEL_WORD:   rd_data = word_q;
      SEL_DATA:   rd_data = data_q;
      default:    rd_data = status_byte(proto_q, busy, eeprom_busy, err_q);
    endcase
  end
endmodule

// File: rtl/sbus_seq.sv
`timescale 1ns/1ps
module sbus_seq
  import sbus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       launch,
  input  logic [7:0] tgt,
  input  logic [7:0] wa,
  input  logic [7:0] wd,
  input  logic       no_word,
  input  logic       sda_in,
  output logic       busy,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       rx_done,
  output logic [7:0] rx_byte,
  output logic       nack_evt,
  output logic       edge_ok,
  output logic       in_rx
);
  step_t      step;
  logic [1:0] q;
  logic [3:0] bitn;
  logic [7:0] shreg;
  logic       ack_s;

  logic       byte_step;
  logic       step_end;
  logic       nack_now;
  logic [7:0] cur_byte;
  logic [2:0] bidx;
  logic       tx_bit;

  assign byte_step = is_byte(step);
  assign step_end  = tick && (step != ST_IDLE) && (q == 2'd3) &&
                     (!byte_step || (bitn == 4'd8));
  assign nack_now  = is_tx(step) && ack_s;
  assign nack_evt  = step_end && nack_now;
  assign rx_done   = step_end && (step == ST_RDATA);
  assign rx_byte   = shreg;
  assign busy      = (step != ST_IDLE);
  assign edge_ok   = (step == ST_START) || (step == ST_RSTART) ||
                     (step == ST_STOP);
  assign in_rx     = (step == ST_RDATA);

  assign cur_byte = tx_byte(step, tgt, wa, wd);
  assign bidx     = 3'd7 - bitn[2:0];
  assign tx_bit   = (bitn < 4'd8) ? cur_byte[bidx] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step  <= ST_IDLE;
      q     <= '0;
      bitn  <= '0;
      shreg <= '0;
      ack_s <= 1'b0;
    end else if (launch) begin
      step  <= ST_START;
      q     <= '0;
      bitn  <= '0;
      ack_s <= 1'b0;
    end else if (tick && busy) begin
      q <= q + 2'd1;
      if (byte_step && (q == 2'd2)) begin
        if (bitn < 4'd8) shreg <= {shreg[6:0], sda_in};
        else             ack_s <= sda_in;
      end
      if (q == 2'd3) begin
        if (step_end) begin
          step <= next_step(step, tgt[0], no_word, nack_now);
          bitn <= '0;
        end else begin
          bitn <= bitn + 4'd1;
        end
      end
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (step)
      ST_START: begin
        scl_oe = (q == 2'd3);
        sda_oe = (q >= 2'd2);
      end
      ST_RSTART: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = (q >= 2'd2);
      end
      ST_STOP: begin
        scl_oe = (q == 2'd0);
        sda_oe = (q <= 2'd1);
      end
      ST_IDLE: begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
      end
      default: begin
        scl_oe = (q == 2'd0) || (q == 2'd3);
        sda_oe = is_tx(step) && !tx_bit;
      end
    endcase
  end
endmodule

// File: rtl/sbus_byte_master.sv
`timescale 1ns/1ps
module sbus_byte_master
  import sbus_pkg::*;
#(
  parameter int QDIV = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic [1:0] rd_sel,
  output logic [7:0] rd_data,
  input  logic       eeprom_busy,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  logic       busy;
  logic       launch;
  logic       tick;
  logic [7:0] tgt_q;
  logic [7:0] word_q;
  logic [7:0] data_q;
  logic       proto_q;
  logic       err_q;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       nack_evt;
  logic       edge_ok;
  logic       in_rx;

  sbus_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .busy(busy),
    .eeprom_busy(eeprom_busy), .rx_done(rx_done), .rx_byte(rx_byte),
    .nack_evt(nack_evt), .rd_data(rd_data), .tgt_q(tgt_q),
    .word_q(word_q), .data_q(data_q), .proto_q(proto_q), .err_q(err_q),
    .launch(launch)
  );

  sbus_qtick #(.QDIV(QDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(launch), .run(busy), .tick(tick)
  );

  sbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .launch(launch),
    .tgt(tgt_q), .wa(word_q), .wd(data_q), .no_word(proto_q),
    .sda_in(sda_in), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_done(rx_done), .rx_byte(rx_byte), .nack_evt(nack_evt),
    .edge_ok(edge_ok), .in_rx(in_rx)
  );
endmodule

// File: rtl/sbus_byte_master_chk.sv
`timescale 1ns/1ps
module sbus_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic       eeprom_busy,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       busy,
  input logic [7:0] tgt_q,
  input logic       err_q,
  input logic       nack_evt,
  input logic       edge_ok,
  input logic       in_rx
);
  logic tgt_wr;
  assign tgt_wr = reg_wr && (reg_sel == 2'd0);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && !busy && !eeprom_busy) |=> busy);

  a_r7_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && busy) |=> $stable(tgt_q));

  a_r8_eeprom_block: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_wr && eeprom_busy && !busy) |=> (!busy && $stable(tgt_q)));

  a_r6_nack_sets: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> err_q);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(reg_wr && (reg_sel == 2'd3) && reg_wdata[0])) |=> err_q);

  a_r10_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r10_sda_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> edge_ok);

  a_r4_rx_release: assert property (@(posedge clk) disable iff (!rst_n)
    in_rx |-> !sda_oe);
endmodule

bind sbus_byte_master sbus_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .reg_wdata(reg_wdata), .eeprom_busy(eeprom_busy), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .busy(busy), .tgt_q(tgt_q), .err_q(err_q),
  .nack_evt(nack_evt), .edge_ok(edge_ok), .in_rx(in_rx)
);

// File: tb/sbus_byte_master_bench.sv
`timescale 1ns/1ps
module sbus_byte_master_bench;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [1:0] rd_sel = 2'd3;
  logic [7:0] rd_data;
  logic       ee = 1'b0;
  logic       scl_oe, sda_oe, sda_in;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int m_cnt = 0;
  int exp_q = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sbus_byte_master #(.QDIV(DIV)) u_sbus_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .eeprom_busy(ee), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // behavioural target device on the wires
  logic slv_drv = 1'b0;
  wire  scl_l = !scl_oe;
  wire  sda_l = !(sda_oe || slv_drv);
  assign sda_in = sda_l;

  int b = 0, k = 0, wr_count = 0;
  bit in_frame = 0, slv_tx = 0, pend_tx = 0, word_mode = 1;
  logic [7:0] sh = 0, ptr = 0, txd = 0;
  logic mack = 0;
  logic [7:0] mem [256];
  logic [7:0] aq [$];

  always @(negedge sda_l) if (scl_l === 1'b1) begin
    in_frame = 1; b = 0; k = 0; slv_tx = 0; pend_tx = 0; slv_drv = 0;
  end
  always @(posedge sda_l) if (scl_l === 1'b1) begin
    in_frame = 0; slv_drv = 0;
  end
  always @(posedge scl_l) if (in_frame) begin
    if (!slv_tx && b < 8) sh = {sh[6:0], sda_l};
    if (slv_tx && b == 8) mack = sda_l;
    b++;
  end
  always @(negedge scl_l) if (in_frame) begin
    if (b == 8) begin
      if (!slv_tx) begin
        if (k == 0) begin
          aq.push_back(sh);
          if (sh[7:1] == SLV) begin slv_drv = 1; pend_tx = sh[0]; end
          else in_frame = 0;
        end else if (k == 1 && word_mode) begin
          ptr = sh; slv_drv = 1;
        end else begin
          mem[ptr] = sh; wr_count++; slv_drv = 1;
        end
      end else slv_drv = 0;
    end else if (b == 9) begin
      b = 0; slv_drv = 0;
      if (slv_tx) in_frame = 0;
      else begin
        slv_tx = pend_tx;
        k++;
        if (slv_tx) begin txd = mem[ptr]; slv_drv = !txd[7]; end
      end
    end else if (slv_tx && b >= 1 && b <= 7) begin
      slv_drv = !txd[7-b];
    end
  end

  // cycle-by-cycle busy model
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) m_cnt = 0;
    else if (reg_wr && reg_sel == 2'd0 && m_cnt == 0 && !ee) m_cnt = exp_q * DIV;
    else if (m_cnt > 0) m_cnt--;
  end

  always @(negedge clk) if (rst_n && rd_sel == 2'd3 && !done) begin
    checks++;
    if (rd_data[5] !== (m_cnt > 0)) begin
      errors++;
      $display("FAIL R2 R11 busy at cycle %0d: actual %b expected %b",
               cyc, rd_data[5], (m_cnt > 0));
    end
  end

  always @(posedge clk) if (cyc == 100000 && !done) begin
    done = 1; checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1; reg_sel = s; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] v);
    @(posedge clk); #0.5;
    rd_sel = s;
    #0.5;
    v = rd_data;
    rd_sel = 2'd3;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin @(negedge clk); guard++; end while (m_cnt > 0 && guard < 5000);
    repeat (3) @(negedge clk);
  endtask

  task automatic lines_idle(input string req);
    chk(req, {6'd0, scl_oe, sda_oe}, 8'h00);
  endtask

  logic [7:0] v;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);

    // reset state
    for (int s = 0; s < 4; s++) begin
      reg_read(2'(s), v); chk("R9 reset value", v, 8'h00);
    end
    lines_idle("R10 idle lines after reset");

    // word-address write
    word_mode = 1; aq.delete();
    reg_write(2'd1, 8'h12);
    reg_write(2'd2, 8'hA5);
    exp_q = 116;
    reg_write(2'd0, {SLV, 1'b0});
    repeat (10) @(posedge clk);
    reg_write(2'd0, 8'h47);
    reg_write(2'd2, 8'h00);
    wait_idle();
    chk("R5 written byte", mem[8'h12], 8'hA5);
    chk("R5 write count", 8'(wr_count), 8'd1);
    chk("R1 address count", 8'(aq.size()), 8'd1);
    chk("R1 address byte", aq[0], 8'hA0);
    reg_read(2'd0, v); chk("R7 target kept", v, 8'hA0);
    reg_read(2'd2, v); chk("R7 data kept", v, 8'hA5);
    reg_read(2'd3, v); chk("R6 no error", v, 8'h00);
    lines_idle("R10 idle lines after write");

    // word-address read
    mem[8'h34] = 8'h5C; aq.delete(); mack = 0;
    reg_write(2'd1, 8'h34);
    exp_q = 156;
    reg_write(2'd0, {SLV, 1'b1});
    wait_idle();
    reg_read(2'd2, v); chk("R4 read byte", v, 8'h5C);
    chk("R4 master NACK", 8'(mack), 8'd1);
    chk("R4 address count", 8'(aq.size()), 8'd2);
    chk("R4 first address", aq[0], 8'hA0);
    chk("R4 second address", aq[1], 8'hA1);
    chk("R3 pointer loaded", ptr, 8'h34);

    // address-only write
    word_mode = 0; aq.delete();
    reg_write(2'd3, 8'h80);
    reg_read(2'd3, v); chk("R9 control readback", v, 8'h80);
    reg_write(2'd1, 8'h99);
    reg_write(2'd2, 8'h77);
    exp_q = 80;
    reg_write(2'd0, {SLV, 1'b0});
    wait_idle();
    chk("R3 no word byte, data", mem[8'h34], 8'h77);
    chk("R3 no word byte, count", 8'(wr_count), 8'd2);
    chk("R3 address only", aq[0], 8'hA0);

    // address-only read
    mem[8'h34] = 8'hC3; aq.delete();
    exp_q = 80;
    reg_write(2'd0, {SLV, 1'b1});
    wait_idle();
    reg_read(2'd2, v); chk("R3 short read byte", v, 8'hC3);
    chk("R1 read address", aq[0], 8'hA1);
    chk("R1 address count short read", 8'(aq.size()), 8'd1);

    // missing device, clear landing on the error clock
    word_mode = 1;
    reg_write(2'd3, 8'h00);
    exp_q = 44;
    reg_write(2'd0, 8'h46);
    repeat (40 * DIV - 2) @(posedge clk);
    reg_write(2'd3, 8'h01);
    wait_idle();
    reg_read(2'd3, v); chk("R6 set wins over clear", v, 8'h01);
    reg_write(2'd3, 8'h00);
    reg_read(2'd3, v); chk("R6 zero write keeps error", v, 8'h01);
    reg_write(2'd3, 8'h01);
    reg_read(2'd3, v); chk("R6 write-one clears", v, 8'h00);
    lines_idle("R10 idle lines after nack");

    // preload busy blocks launch
    @(posedge clk); #1 ee = 1;
    reg_read(2'd3, v); chk("R8 preload busy mirror", v, 8'h10);
    reg_write(2'd0, {SLV, 1'b0});
    repeat (8) @(posedge clk);
    reg_read(2'd3, v); chk("R8 no cycle started", v, 8'h10);
    reg_read(2'd0, v); chk("R8 target unchanged", v, 8'h46);
    @(posedge clk); #1 ee = 0;

    // reserved bits
    reg_write(2'd3, 8'hFF);
    reg_read(2'd3, v); chk("R9 reserved bits zero", v, 8'h80);
    reg_write(2'd3, 8'h00);

    repeat (4) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule